// File: doc/BRIEF.md
# Indexed Chipset Configuration Register Bank

This block is the configuration front end of a PC-style chipset. It sits on an 8-bit I/O bus and presents a 256-entry register space through an index port and a data port. Software first writes an index to the index port. It then reads or writes the selected register through the data port. Only a fixed set of indices holds writable storage, and one of them keeps a single bit of what is written. Every other index returns a constant and ignores writes.

The same block holds the system control port. Bit 1 of that port drives the alternate A20 gate. A 0-to-1 change of bit 0 fires a one-cycle CPU soft-reset pulse. The misc status register reports the live A20 bit in its bit 6. The contents of every writable register are driven out as registered outputs, so that the memory decoders elsewhere on the chip can use them.

Register indices (hexadecimal):

| Index | Register | Reset value | Write behaviour |
|---|---|---|---|
| 01 | DMA wait | 00 | read-only |
| 40 | version | 0A | read-only |
| 41 | clock control | 02 | all bits |
| 42 | peripheral control | 80 | all bits |
| 43 | misc status | 37 | read-only |
| 44 | power management | 00 | bit 6 only |
| 45 | ROM enable | C0 | all bits |
| 46 | RAM write protect | 00 | all bits |
| 47 | shadow enable 0 | 00 | all bits |
| 48 | shadow enable 1 | 00 | all bits |
| 49 | shadow enable 2 | 00 | all bits |
| 4A | DRAM configuration | 02 | all bits |
| 4B | extended boundary | 00 | all bits |
| 4C | EMS control | 00 | all bits |
| others | unused | FF | read-only |

Top module: `cfg_regbank_top`

## Requirements
- R1: A write to I/O address 0x22 latches the 8-bit register index. A read or write at 0x23 then reaches the register that this index selects, from the next bus cycle on.
- R2: A write at 0x23 to a writable index (0x41, 0x42, 0x45 to 0x4C) stores the data byte. The value reads back through 0x23, and it shows on the matching output port from the clock edge that accepts the write.
- R3: A write at 0x23 to any other index, including the read-only indices 0x01, 0x40 and 0x43, changes neither the read-back value nor any output.
- R4: A write to power management (0x44) keeps only bit 6 of the data byte. The other seven bits are stored as 0.
- R5: After reset the registers hold the values in the table: 0x01=0x00, 0x40=0x0A, 0x41=0x02, 0x42=0x80, 0x43=0x37, 0x45=0xC0, 0x4A=0x02. The other writable indices hold 0x00, and every remaining index holds 0xFF.
- R6: A read of misc status (0x43) returns its stored value with bit 6 replaced by bit 1 of the system control port.
- R7: The system control port at 0x92 reads back the last byte written to it. The a20_alt output equals bit 1 of that byte from the edge that accepts the write.
- R8: A write to 0x92 with bit 0 set, when the bit was 0 before, raises cpu_soft_reset for exactly the one cycle after the write edge. A write that leaves bit 0 at 1 raises no pulse.
- R9: A read at 0x23 or 0x92 returns its data with io_rvalid high one cycle after io_rd is sampled. A read of any other address returns 0xFF with io_rvalid low.
- R10: The system control port resets to 0x00, so a20_alt is low and cpu_soft_reset stays low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Registered read data |
| io_rvalid | output | 1 | High when io_rdata answers a decoded read |
| a20_alt | output | 1 | Alternate A20 gate enable |
| cpu_soft_reset | output | 1 | One-cycle CPU soft-reset pulse |
| clk_ctl | output | 8 | Clock control register |
| periph_ctl | output | 8 | Peripheral control register |
| pwr_mgmt | output | 8 | Power management register |
| rom_en | output | 8 | ROM enable register |
| ram_wp | output | 8 | RAM write protect register |
| shadow_en | output | 24 | Shadow enables 2,1,0 from high byte to low |
| dram_cfg | output | 8 | DRAM configuration register |
| ext_bound | output | 8 | Extended boundary register |
| ems_ctl | output | 8 | EMS control register |

## Verification
Each write takes effect at the edge that samples io_wr. The register outputs and a20_alt can therefore be checked at the falling edge that follows that edge. The soft-reset pulse is checked at that same falling edge and then found low one falling edge later. Read data and io_rvalid are registered, so the bench raises io_rd at a falling edge and samples at the next falling edge. An index write always comes one full bus cycle before the data access that relies on it.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

  localparam int DATA_W = 8;
  localparam int IDX_W  = 8;
  localparam int NUM_WR = 11;

  localparam logic [IDX_W-1:0] IX_DMA_WAIT = 8'h01;
  localparam logic [IDX_W-1:0] IX_VERSION  = 8'h40;
  localparam logic [IDX_W-1:0] IX_CLK      = 8'h41;
  localparam logic [IDX_W-1:0] IX_PERIPH   = 8'h42;
  localparam logic [IDX_W-1:0] IX_MISC     = 8'h43;
  localparam logic [IDX_W-1:0] IX_PWR      = 8'h44;
  localparam logic [IDX_W-1:0] IX_ROM      = 8'h45;
  localparam logic [IDX_W-1:0] IX_WP       = 8'h46;
  localparam logic [IDX_W-1:0] IX_SH0      = 8'h47;
  localparam logic [IDX_W-1:0] IX_SH1      = 8'h48;
  localparam logic [IDX_W-1:0] IX_SH2      = 8'h49;
  localparam logic [IDX_W-1:0] IX_DRAM     = 8'h4A;
  localparam logic [IDX_W-1:0] IX_EXTB     = 8'h4B;
  localparam logic [IDX_W-1:0] IX_EMS      = 8'h4C;

  // slot numbers of the writable registers
  localparam int S_CLK = 0, S_PERIPH = 1, S_PWR = 2, S_ROM = 3, S_WP = 4;
  localparam int S_SH0 = 5, S_SH1 = 6, S_SH2 = 7, S_DRAM = 8, S_EXTB = 9, S_EMS = 10;

  function automatic logic [IDX_W-1:0] slot_index(input int k);
    case (k)
      S_CLK:    return IX_CLK;
      S_PERIPH: return IX_PERIPH;
      S_PWR:    return IX_PWR;
      S_ROM:    return IX_ROM;
      S_WP:     return IX_WP;
      S_SH0:    return IX_SH0;
      S_SH1:    return IX_SH1;
      S_SH2:    return IX_SH2;
      S_DRAM:   return IX_DRAM;
      S_EXTB:   return IX_EXTB;
      default:  return IX_EMS;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_reset(input int k);
    case (k)
      S_CLK:    return 8'h02;
      S_PERIPH: return 8'h80;
      S_ROM:    return 8'hC0;
      S_DRAM:   return 8'h02;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_mask(input int k);
    if (k == S_PWR) return 8'h40;
    return 8'hFF;
  endfunction

  // value of an index that has no writable storage
  function automatic logic [DATA_W-1:0] fixed_value(input logic [IDX_W-1:0] idx);
    case (idx)
      IX_DMA_WAIT: return 8'h00;
      IX_VERSION:  return 8'h0A;
      IX_MISC:     return 8'h37;
      default:     return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/cfg_io_decode.sv
module cfg_io_decode #(
  parameter int              ADDR_W   = 16,
  parameter logic [15:0]     IDX_PORT = 16'h0022,
  parameter logic [15:0]     DAT_PORT = 16'h0023,
  parameter logic [15:0]     SYS_PORT = 16'h0092
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              idx_wr,
  output logic              dat_wr,
  output logic              dat_rd,
  output logic              sys_wr,
  output logic              sys_rd
);
  logic hit_idx, hit_dat, hit_sys;

  assign hit_idx = (io_addr == ADDR_W'(IDX_PORT));
  assign hit_dat = (io_addr == ADDR_W'(DAT_PORT));
  assign hit_sys = (io_addr == ADDR_W'(SYS_PORT));

  assign idx_wr = io_wr & hit_idx;
  assign dat_wr = io_wr & hit_dat;
  assign dat_rd = io_rd & hit_dat;
  assign sys_wr = io_wr & hit_sys;
  assign sys_rd = io_rd & hit_sys;
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_regbank_pkg::*;
#(
  parameter int NUM = NUM_WR
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM-1:0][DATA_W-1:0] slot_q,
  output logic                       rd_hit,
  output logic [DATA_W-1:0]          rd_value
);
  logic [NUM-1:0] hit;

  for (genvar k = 0; k < NUM; k++) begin : g_slot
    assign hit[k] = (idx == slot_index(k));
    always_ff @(posedge clk) begin
      if (rst)
        slot_q[k] <= slot_reset(k);
      else if (wr_en && hit[k])
        slot_q[k] <= wr_data & slot_mask(k);
    end
  end

  always_comb begin
    rd_value = '0;
    for (int k = 0; k < NUM; k++)
      if (hit[k]) rd_value = rd_value | slot_q[k];
  end

  assign rd_hit = |hit;
endmodule

// File: rtl/cfg_sysctl_port.sv
module cfg_sysctl_port #(
  parameter int DATA_W  = 8,
  parameter int A20_BIT = 1,
  parameter int RST_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] port_q,
  output logic              a20,
  output logic              soft_rst
);
  always_ff @(posedge clk) begin
    if (rst) begin
      port_q   <= '0;
      soft_rst <= 1'b0;
    end else begin
      soft_rst <= wr_en & wr_data[RST_BIT] & ~port_q[RST_BIT];
      if (wr_en) port_q <= wr_data;
    end
  end

  assign a20 = port_q[A20_BIT];
endmodule

// File: rtl/cfg_regbank_top.sv
module cfg_regbank_top
  import cfg_regbank_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] IDX_PORT = 16'h0022,
  parameter logic [15:0] DAT_PORT = 16'h0023,
  parameter logic [15:0] SYS_PORT = 16'h0092,
  parameter int          A20_BIT  = 1,
  parameter int          RST_BIT  = 0,
  parameter int          MISC_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic              a20_alt,
  output logic              cpu_soft_reset,
  output logic [7:0]        clk_ctl,
  output logic [7:0]        periph_ctl,
  output logic [7:0]        pwr_mgmt,
  output logic [7:0]        rom_en,
  output logic [7:0]        ram_wp,
  output logic [23:0]       shadow_en,
  output logic [7:0]        dram_cfg,
  output logic [7:0]        ext_bound,
  output logic [7:0]        ems_ctl
);
  logic                          idx_wr, dat_wr, dat_rd, sys_wr, sys_rd;
  logic [IDX_W-1:0]              idx_q;
  logic [NUM_WR-1:0][DATA_W-1:0] slot_q;
  logic                          rd_hit;
  logic [DATA_W-1:0]             rd_slot, dat_value, sys_q, misc_merged;

  cfg_io_decode #(
    .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT), .SYS_PORT(SYS_PORT)
  ) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .idx_wr(idx_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .sys_wr(sys_wr), .sys_rd(sys_rd)
  );

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_wr) idx_q <= io_wdata;
  end

  cfg_reg_file #(.NUM(NUM_WR)) u_regs (
    .clk(clk), .rst(rst), .wr_en(dat_wr), .idx(idx_q), .wr_data(io_wdata),
    .slot_q(slot_q), .rd_hit(rd_hit), .rd_value(rd_slot)
  );

  cfg_sysctl_port #(.DATA_W(DATA_W), .A20_BIT(A20_BIT), .RST_BIT(RST_BIT)) u_sys (
    .clk(clk), .rst(rst), .wr_en(sys_wr), .wr_data(io_wdata),
    .port_q(sys_q), .a20(a20_alt), .soft_rst(cpu_soft_reset)
  );

  always_comb begin
    misc_merged           = fixed_value(IX_MISC);
    misc_merged[MISC_BIT] = sys_q[A20_BIT];
    if (rd_hit)               dat_value = rd_slot;
    else if (idx_q == IX_MISC) dat_value = misc_merged;
    else                      dat_value = fixed_value(idx_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rvalid <= 1'b0;
      io_rdata  <= 8'hFF;
    end else begin
      io_rvalid <= dat_rd | sys_rd;
      if (sys_rd)      io_rdata <= sys_q;
      else if (dat_rd) io_rdata <= dat_value;
      else             io_rdata <= 8'hFF;
    end
  end

  assign clk_ctl    = slot_q[S_CLK];
  assign periph_ctl = slot_q[S_PERIPH];
  assign pwr_mgmt   = slot_q[S_PWR];
  assign rom_en     = slot_q[S_ROM];
  assign ram_wp     = slot_q[S_WP];
  assign shadow_en  = {slot_q[S_SH2], slot_q[S_SH1], slot_q[S_SH0]};
  assign dram_cfg   = slot_q[S_DRAM];
  assign ext_bound  = slot_q[S_EXTB];
  assign ems_ctl    = slot_q[S_EMS];
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] DAT_PORT = 16'h0023,
  parameter logic [15:0] SYS_PORT = 16'h0092
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic              io_rvalid,
  input logic              a20_alt,
  input logic              cpu_soft_reset,
  input logic [7:0]        pwr_mgmt,
  input logic [7:0]        ems_ctl,
  input logic [7:0]        dram_cfg
);
  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_soft_reset |=> !cpu_soft_reset);
  // R8
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_soft_reset |-> ($past(io_wr) && $past(io_addr) == ADDR_W'(SYS_PORT) && $past(io_wdata[0])));
  // R7
  a20_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == ADDR_W'(SYS_PORT)) |=> (a20_alt == $past(io_wdata[1])));
  // R9
  undecoded_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr != ADDR_W'(DAT_PORT) && io_addr != ADDR_W'(SYS_PORT))
      |=> (!io_rvalid && io_rdata == 8'hFF));
  // R9
  rvalid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> $past(io_rd));
  // R4
  pwr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_mgmt & 8'hBF) == 8'h00);
  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_addr == ADDR_W'(DAT_PORT)) |=> ($stable(ems_ctl) && $stable(dram_cfg)));
endmodule

bind cfg_regbank_top cfg_regbank_chk #(
  .ADDR_W(ADDR_W), .DAT_PORT(DAT_PORT), .SYS_PORT(SYS_PORT)
) u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
  .io_rd(io_rd), .io_rdata(io_rdata), .io_rvalid(io_rvalid), .a20_alt(a20_alt),
  .cpu_soft_reset(cpu_soft_reset), .pwr_mgmt(pwr_mgmt), .ems_ctl(ems_ctl),
  .dram_cfg(dram_cfg)
);

// File: tb/cfg_regbank_top_tb.sv
`timescale 1ns/1ps
module cfg_regbank_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata, clk_ctl, periph_ctl, pwr_mgmt, rom_en, ram_wp;
  logic [7:0]  dram_cfg, ext_bound, ems_ctl;
  logic [23:0] shadow_en;
  logic        io_rvalid, a20_alt, cpu_soft_reset;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] model [256];
  logic [7:0] sys_model = 8'h00;

  always #10 clk = ~clk;

  cfg_regbank_top u_dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
    .io_rd(io_rd), .io_rdata(io_rdata), .io_rvalid(io_rvalid), .a20_alt(a20_alt),
    .cpu_soft_reset(cpu_soft_reset), .clk_ctl(clk_ctl), .periph_ctl(periph_ctl),
    .pwr_mgmt(pwr_mgmt), .rom_en(rom_en), .ram_wp(ram_wp), .shadow_en(shadow_en),
    .dram_cfg(dram_cfg), .ext_bound(ext_bound), .ems_ctl(ems_ctl)
  );

  function automatic logic [7:0] exp_reset(input logic [7:0] i);
    case (i)
      8'h01: return 8'h00;
      8'h40: return 8'h0A;
      8'h41: return 8'h02;
      8'h42: return 8'h80;
      8'h43: return 8'h37;
      8'h45: return 8'hC0;
      8'h4A: return 8'h02;
      8'h44, 8'h46, 8'h47, 8'h48, 8'h49, 8'h4B, 8'h4C: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit exp_writable(input logic [7:0] i);
    return (i == 8'h41) || (i == 8'h42) || (i >= 8'h44 && i <= 8'h4C);
  endfunction

  function automatic logic [7:0] exp_stored(input logic [7:0] i, input logic [7:0] d);
    return (i == 8'h44) ? (d & 8'h40) : d;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] i);
    if (i == 8'h43) return (model[i] & 8'hBF) | {1'b0, sys_model[1], 6'b0};
    return model[i];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); d = io_rdata; v = io_rvalid; io_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] i, input logic [7:0] d);
    io_write(16'h0022, i);
    io_write(16'h0023, d);
    if (exp_writable(i)) model[i] = exp_stored(i, d);
  endtask

  task automatic reg_check(input logic [7:0] i, input string tag);
    logic [7:0] d; logic v;
    io_write(16'h0022, i);
    io_read(16'h0023, d, v);
    chk(v && d == exp_read(i), tag, {23'b0, v, d}, {24'h1, exp_read(i)});
  endtask

  task automatic outputs_check(input string tag);
    chk(clk_ctl == model[8'h41] && periph_ctl == model[8'h42] && pwr_mgmt == model[8'h44] &&
        rom_en == model[8'h45] && ram_wp == model[8'h46] && dram_cfg == model[8'h4A] &&
        ext_bound == model[8'h4B] && ems_ctl == model[8'h4C], tag,
        {clk_ctl, dram_cfg, ext_bound, ems_ctl}, {model[8'h41], model[8'h4A], model[8'h4B], model[8'h4C]});
    chk(shadow_en == {model[8'h49], model[8'h48], model[8'h47]}, tag,
        {8'h0, shadow_en}, {8'h0, model[8'h49], model[8'h48], model[8'h47]});
  endtask

  // R7 R8 : write the control port, check the pulse and A20 at the edges that follow
  task automatic sys_write(input logic [7:0] d);
    logic exp_pulse;
    exp_pulse = d[0] & ~sys_model[0];
    @(negedge clk); io_addr = 16'h0092; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
    sys_model = d;
    chk(cpu_soft_reset == exp_pulse, "R8 pulse", {31'b0, cpu_soft_reset}, {31'b0, exp_pulse});
    chk(a20_alt == d[1], "R7 a20", {31'b0, a20_alt}, {31'b0, d[1]});
    @(negedge clk);
    chk(cpu_soft_reset == 1'b0, "R8 pulse width", {31'b0, cpu_soft_reset}, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, i, v8;
    logic v;
    void'($urandom(32'h5EED1234));
    for (int k = 0; k < 256; k++) model[k] = exp_reset(8'(k));
    repeat (3) @(negedge clk);
    // R10 : outputs during reset
    chk(cpu_soft_reset == 1'b0 && a20_alt == 1'b0, "R10 in reset", {30'b0, a20_alt, cpu_soft_reset}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_soft_reset == 1'b0 && a20_alt == 1'b0, "R10 after reset", {30'b0, a20_alt, cpu_soft_reset}, 32'h0);
    io_read(16'h0092, d, v);
    chk(v && d == 8'h00, "R10 sys readback", {23'b0, v, d}, 32'h100);
    // R5 : every index at its reset value, R6 with A20 low
    for (int k = 0; k < 256; k++) reg_check(8'(k), "R5 reset value");
    outputs_check("R5 reset outputs");

    // R2 : directed writes to every writable index
    for (int k = 8'h41; k <= 8'h4C; k++) begin
      if (exp_writable(8'(k))) begin
        reg_write(8'(k), 8'(8'hA5 ^ k));
        reg_check(8'(k), "R2 directed readback");
      end
    end
    outputs_check("R2 directed outputs");
    // R4 : power management mask
    reg_write(8'h44, 8'hFF);
    reg_check(8'h44, "R4 mask ones");
    chk(pwr_mgmt == 8'h40, "R4 output", {24'b0, pwr_mgmt}, 32'h40);
    reg_write(8'h44, 8'hBF);
    reg_check(8'h44, "R4 mask bit6 clear");
    // R3 : read-only and unused indices ignore writes
    reg_write(8'h40, 8'h55); reg_check(8'h40, "R3 version");
    reg_write(8'h43, 8'hFF); reg_check(8'h43, "R3 misc");
    reg_write(8'h01, 8'h77); reg_check(8'h01, "R3 dma wait");
    reg_write(8'h4D, 8'h00); reg_check(8'h4D, "R3 unused");
    outputs_check("R3 outputs unchanged");
    // R1 : index change without data write selects a different register
    reg_write(8'h4B, 8'h3C);
    reg_write(8'h4C, 8'hC3);
    reg_check(8'h4B, "R1 index select");
    reg_check(8'h4C, "R1 index select");

    // R8 R7 R6 : control port corner cases
    sys_write(8'h01);
    sys_write(8'h03);
    sys_write(8'h02);
    reg_check(8'h43, "R6 misc A20 high");
    io_read(16'h0092, d, v);
    chk(v && d == 8'h02, "R7 sys readback", {23'b0, v, d}, 32'h102);
    sys_write(8'h00);
    reg_check(8'h43, "R6 misc A20 low");

    // R9 : undecoded reads
    io_read(16'h0022, d, v);
    chk(!v && d == 8'hFF, "R9 index port read", {23'b0, v, d}, 32'hFF);
    io_read(16'h0223, d, v);
    chk(!v && d == 8'hFF, "R9 alias read", {23'b0, v, d}, 32'hFF);

    // random mix against the model
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 5)
        0, 1: begin
          i = ($urandom % 2) ? 8'(8'h3E + $urandom % 18) : 8'($urandom);
          reg_write(i, 8'($urandom));
          reg_check(i, "R2 R3 R4 random write");
        end
        2: begin
          i = 8'($urandom);
          reg_check(i, "R1 R6 random read");
        end
        3: begin
          v8 = 8'($urandom);
          sys_write(v8);
          io_read(16'h0092, d, v);
          chk(v && d == sys_model, "R7 random sys", {23'b0, v, d}, {24'h1, sys_model});
        end
        default: begin
          io_addr = 16'($urandom);
          if (io_addr == 16'h0023 || io_addr == 16'h0092) io_addr = 16'h0300;
          io_read(io_addr, d, v);
          chk(!v && d == 8'hFF, "R9 random undecoded", {23'b0, v, d}, 32'hFF);
        end
      endcase
    end
    outputs_check("R2 final outputs");
    reg_check(8'h43, "R6 final misc");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule